// File: doc/BRIEF.md
# Programmable Pin Wakeup Detector

This block runs on the always-on clock and watches one pad bit for a programmed wakeup event. The event is chosen by a 3-bit mode: a rising edge, a falling edge, an edge in either direction, or the level staying high or low for a programmed number of cycles. When the event is seen, a sticky cause bit is set. The wakeup request to the power controller is high for as long as that bit is set. Software clears the bit with a one-cycle clear pulse.

An optional debounce stage passes a new pad level on only after the pad has held that level for four consecutive cycles. The pad selection mux and the register crossing into this clock domain sit outside the block. The pad bit and the configuration arrive here already selected and already synchronous.

Top module: `pin_wake_detector`

## Requirements
- R1: After reset, `cause` and `wake_req` are 0.
- R2: Mode 0 (rising edge): with the filter off, a 0-to-1 change of `pad_i` between two consecutive clock edges sets `cause` at the second edge. A 1-to-0 change or a steady level has no effect.
- R3: Mode 1 (falling edge): a 1-to-0 change of the detected level sets `cause`. A 0-to-1 change does not.
- R4: Mode 2 (either edge): a change of the detected level in either direction sets `cause`.
- R5: Mode values 5, 6 and 7 behave exactly like mode 0.
- R6: Mode 3 (timed high) and mode 4 (timed low): `cause` is set at the clock edge that is the `thresh`-th consecutive edge at which the detected level equals the target level (1 for mode 3, 0 for mode 4). Any edge at which the level is off target restarts the count. The count is 8 bits wide and saturates.
- R7: Changing `mode` while `det_en` is 1 does not clear the duration count. High time accumulated under another mode whose target is high still counts once mode 3 is selected again.
- R8: With `filt_en` at 1, the detected level takes a new `pad_i` value only after `pad_i` has held it at 4 consecutive clock edges. That value is forwarded at the following edge, and an edge event sets `cause` one edge after that. Pulses shorter than 4 cycles are dropped.
- R9: While `det_en` is 0, no event sets `cause` and the duration count is held at 0. The edge history keeps tracking the level, so enabling the detector while the pad is steady raises no event.
- R10: `cause` stays set until a cycle with `cause_clr` at 1 clears it at the next edge. If a new event is detected in that same cycle, the event wins and `cause` stays 1.
- R11: `wake_req` equals `cause` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_i | input | 1 | Selected pad level, already synchronous to `clk` |
| det_en | input | 1 | Detector enable |
| mode | input | 3 | Event select: 0 rise, 1 fall, 2 either edge, 3 timed high, 4 timed low, 5-7 rise |
| filt_en | input | 1 | Enables the 4-cycle stability filter |
| thresh | input | 8 | Cycle threshold for the timed modes |
| cause_clr | input | 1 | Software clear of the cause bit, one cycle |
| wake_req | output | 1 | Wakeup request |
| cause | output | 1 | Sticky cause bit |

## Verification
Every internal state of this block reaches the ports only through the single cause bit, so an error appears as a wakeup that comes one or more edges too early, too late, or not at all. A stale edge-history register shows on the first edge after enable, or after the filter releases a level. A wrong duration count shows at the threshold edge of a timed mode. A filter stability counter that is off by one moves the wakeup by one cycle. The checks therefore sample `cause` on the exact edge before and the exact edge of each expected event.

// File: rtl/pin_wake_detector.sv
module pin_wake_detector #(
  parameter int CNT_W    = 8,
  parameter int MODE_W   = 3,
  parameter int FILT_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pad_i,
  input  logic              det_en,
  input  logic [MODE_W-1:0] mode,
  input  logic              filt_en,
  input  logic [CNT_W-1:0]  thresh,
  input  logic              cause_clr,
  output logic              wake_req,
  output logic              cause
);
  localparam int SC_W = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;
  localparam logic [SC_W-1:0]   SC_MAX  = SC_W'(FILT_CYC - 1);
  localparam logic [MODE_W-1:0] M_RISE  = MODE_W'(0);
  localparam logic [MODE_W-1:0] M_FALL  = MODE_W'(1);
  localparam logic [MODE_W-1:0] M_ANY   = MODE_W'(2);
  localparam logic [MODE_W-1:0] M_T_HI  = MODE_W'(3);
  localparam logic [MODE_W-1:0] M_T_LO  = MODE_W'(4);

  logic            cand_q, filt_q, prev_q, cause_q;
  logic [SC_W-1:0] stab_q;
  logic [CNT_W-1:0] dur_q, dur_inc;
  logic            lvl, rise, fall, at_tgt, timed_hit, evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= 1'b0;
      stab_q <= '0;
      filt_q <= 1'b0;
    end else begin
      cand_q <= pad_i;
      if (pad_i != cand_q)   stab_q <= '0;
      else if (stab_q != SC_MAX) stab_q <= stab_q + 1'b1;
      if (stab_q == SC_MAX)  filt_q <= cand_q;
    end
  end

  assign lvl     = filt_en ? filt_q : pad_i;
  assign rise    = lvl & ~prev_q;
  assign fall    = ~lvl & prev_q;
  assign at_tgt  = (lvl == (mode != M_T_LO));
  assign dur_inc = (&dur_q) ? dur_q : dur_q + 1'b1;
  assign timed_hit = at_tgt && (dur_inc >= thresh);

  always_comb begin
    unique case (mode)
      M_RISE:         evt = rise;
      M_FALL:         evt = fall;
      M_ANY:          evt = rise | fall;
      M_T_HI, M_T_LO: evt = timed_hit;
      default:        evt = rise;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      dur_q   <= '0;
      cause_q <= 1'b0;
    end else begin
      prev_q  <= lvl;
      dur_q   <= (det_en && at_tgt) ? dur_inc : '0;
      cause_q <= (det_en & evt) | (cause_q & ~cause_clr);
    end
  end

  assign cause    = cause_q;
  assign wake_req = cause_q;
endmodule

// File: rtl/pin_wake_detector_chk.sv
module pin_wake_detector_chk #(
  parameter int CNT_W  = 8,
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pad_i,
  input logic              det_en,
  input logic [MODE_W-1:0] mode,
  input logic              filt_en,
  input logic [CNT_W-1:0]  thresh,
  input logic              cause_clr,
  input logic              wake_req,
  input logic              cause
);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cause && !cause_clr |=> cause);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cause_clr && !det_en |=> !cause);

  a_r9_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en && !cause |=> !cause);

  a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && det_en && mode == MODE_W'(0) && !filt_en && $past(!filt_en)
    && pad_i && !$past(pad_i) |=> cause);

  a_r3_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && det_en && mode == MODE_W'(1) && !filt_en && $past(!filt_en)
    && !pad_i && $past(pad_i) |=> cause);

  a_r11_wake_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause) |-> wake_req);
endmodule

bind pin_wake_detector pin_wake_detector_chk #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pad_i(pad_i), .det_en(det_en), .mode(mode),
  .filt_en(filt_en), .thresh(thresh), .cause_clr(cause_clr),
  .wake_req(wake_req), .cause(cause)
);

// File: tb/pin_wake_detector_bench.sv
`timescale 1ns/1ps
module pin_wake_detector_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pad_i = 1'b0, det_en = 1'b0, filt_en = 1'b0, cause_clr = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [7:0] thresh = 8'd0;
  logic wake_req, cause;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pin_wake_detector u_pin_wake_detector (
    .clk(clk), .rst_n(rst_n), .pad_i(pad_i), .det_en(det_en), .mode(mode),
    .filt_en(filt_en), .thresh(thresh), .cause_clr(cause_clr),
    .wake_req(wake_req), .cause(cause)
  );

  // {mode[2:0], level before, level after, expected cause}
  localparam logic [5:0] VEC [10] = '{
    {3'd0, 1'b0, 1'b1, 1'b1}, {3'd0, 1'b1, 1'b0, 1'b0},
    {3'd1, 1'b1, 1'b0, 1'b1}, {3'd1, 1'b0, 1'b1, 1'b0},
    {3'd2, 1'b0, 1'b1, 1'b1}, {3'd2, 1'b1, 1'b0, 1'b1},
    {3'd5, 1'b0, 1'b1, 1'b1}, {3'd6, 1'b0, 1'b1, 1'b1},
    {3'd7, 1'b1, 1'b0, 1'b0}, {3'd0, 1'b1, 1'b1, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic park(input logic [2:0] m, input logic p, input logic f);
    det_en = 1'b0; cause_clr = 1'b1; mode = m; pad_i = p; filt_en = f;
    step(1);
    cause_clr = 1'b0;
  endtask

  initial begin
    #1600000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    chk(cause, 1'b0, "R1 cause after reset");
    chk(wake_req, 1'b0, "R1 wake after reset");
    rst_n = 1'b1;
    step(2);
    chk(cause, 1'b0, "R1 cause after release");

    for (int i = 0; i < 10; i++) begin
      string tag;
      tag = (VEC[i][5:3] == 3'd1) ? "R3" : (VEC[i][5:3] == 3'd2) ? "R4" :
            (VEC[i][5:3] >= 3'd5) ? "R5" : "R2";
      park(VEC[i][5:3], VEC[i][2], 1'b0);
      det_en = 1'b1;
      step(2);
      pad_i = VEC[i][1];
      step(1);
      chk(cause, VEC[i][0], tag);
      chk(wake_req, cause, "R11 wake equals cause");
    end

    // R6 timed high, threshold 5
    park(3'd3, 1'b0, 1'b0);
    thresh = 8'd5; det_en = 1'b1;
    step(1);
    pad_i = 1'b1;
    step(4);
    chk(cause, 1'b0, "R6 timed high before threshold");
    step(1);
    chk(cause, 1'b1, "R6 timed high at threshold");
    chk(wake_req, 1'b1, "R11 wake on timed event");

    // R6 timed low with an interruption, threshold 3
    park(3'd4, 1'b1, 1'b0);
    thresh = 8'd3; det_en = 1'b1;
    step(1);
    pad_i = 1'b0; step(2);
    pad_i = 1'b1; step(1);
    pad_i = 1'b0; step(2);
    chk(cause, 1'b0, "R6 timed low count restarted");
    step(1);
    chk(cause, 1'b1, "R6 timed low at threshold");

    // R7 count survives a mode change
    park(3'd3, 1'b0, 1'b0);
    thresh = 8'd6; det_en = 1'b1;
    step(1);
    pad_i = 1'b1; step(3);
    mode = 3'd1; step(2);
    chk(cause, 1'b0, "R7 no event under other mode");
    mode = 3'd3; step(1);
    chk(cause, 1'b1, "R7 accumulated count reaches threshold");

    // R8 filter
    park(3'd0, 1'b0, 1'b1);
    step(6);
    det_en = 1'b1; step(1);
    pad_i = 1'b1; step(3);
    pad_i = 1'b0; step(8);
    chk(cause, 1'b0, "R8 short pulse filtered");
    pad_i = 1'b1; step(5);
    chk(cause, 1'b0, "R8 filtered edge not yet seen");
    step(1);
    chk(cause, 1'b1, "R8 filtered edge after stability");

    // R9 disabled detector and clean enable
    park(3'd2, 1'b0, 1'b0);
    pad_i = 1'b1; step(1);
    pad_i = 1'b0; step(1);
    pad_i = 1'b1; step(1);
    chk(cause, 1'b0, "R9 no detection while disabled");
    det_en = 1'b1; step(2);
    chk(cause, 1'b0, "R9 no stale edge on enable");
    pad_i = 1'b0; step(1);
    chk(cause, 1'b1, "R9 R4 detection after enable");

    // R10 sticky, clear, and event over clear
    step(3);
    chk(cause, 1'b1, "R10 cause sticky");
    cause_clr = 1'b1; step(1);
    cause_clr = 1'b0;
    chk(cause, 1'b0, "R10 clear pulse");
    chk(wake_req, 1'b0, "R11 wake drops with cause");
    pad_i = 1'b1; cause_clr = 1'b1; step(1);
    cause_clr = 1'b0;
    chk(cause, 1'b1, "R10 event wins over clear");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule